// File: doc/BRIEF.md
# SECDED Hamming Codeword Encoder with Fault Injection

This block turns a data word into a single-error-correcting, double-error-detecting Hamming codeword, ready to be written into a storage array. The data word passes through unchanged in the low bits of the codeword. The Hamming check bits sit above it. When double-error detection is enabled, one overall parity bit sits at the very top.

A two-bit injection control can deliberately corrupt the outgoing codeword by one or two bits. This lets a downstream decoder's correction and detection paths be exercised without touching the memory. The corruption is applied after encoding, so the check bits always describe the clean data.

The encoder is a fixed-latency pipeline that accepts a new word every cycle. It has no flow control: every clock edge advances the pipeline. It has two register stages by default. A parameter adds a third stage for wide words.

Top module: `ecc_secded_encoder`

## Requirements
- R1: Codeword bits [DATA_W-1:0] carry the input data word unmodified, except for bits that injection flips. The check bits occupy bits [CW_W-1:DATA_W].
- R2: The number of check bits is the smallest P with 2^P >= DATA_W+P+1. For DATA_W=64 the codeword is 72 bits wide with double-error detection and 71 bits wide without it.
- R3: Data bit j is given the (j+1)-th Hamming position that is not a power of two, counting up from position 3. Check bit i (codeword bit DATA_W+i) is the even parity of every data bit whose position has bit i set.
- R4: With double-error detection enabled, the top codeword bit makes the whole clean codeword even parity.
- R5: A word presented at one rising edge appears on code_out after 2 rising edges with EXTRA_PIPE=0, or after 3 with EXTRA_PIPE=1. A new word is accepted every cycle.
- R6: inj_mode 2'b01 flips codeword bit 0 only.
- R7: inj_mode 2'b10 flips codeword bits 0 and 1.
- R8: inj_mode 2'b00, and the reserved code 2'b11, leave the codeword uncorrupted.
- R9: The synchronous reset rst clears every pipeline register, so code_out reads all zeros on the edge after reset is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | DATA_W | Data word to encode, sampled every rising edge |
| inj_mode | input | 2 | Injection control: 00 none, 01 one bit, 10 two bits, 11 none |
| code_out | output | CW_W | Registered codeword: data, then check bits, then overall parity |

## Verification
A wrong parity selection in the XOR network shows up as a wrong check-bit field on code_out exactly 2 (or 3) cycles after the offending word, and only for data patterns that touch the bad position. Random data combined with single-bit walking words is therefore used so that every check bit sees every data bit. A stale or misaligned injection control shows at the same cycle as a mismatch in bits 0 and 1 of the codeword and a wrong overall parity. A pipeline register that misses reset shows as non-zero bits on the first cycle after reset.

// File: rtl/ecc_enc_pkg.sv
package ecc_enc_pkg;

  localparam int MAX_DATA_W = 1024;
  localparam int MAX_POS    = 2048;

  typedef enum logic [1:0] {
    INJ_NONE = 2'b00,
    INJ_ONE  = 2'b01,
    INJ_TWO  = 2'b10,
    INJ_RSVD = 2'b11
  } inj_mode_e;

  // Smallest number of Hamming check bits covering n data bits.
  function automatic int chk_bits(input int n);
    int res;
    res = 0;
    for (int p = 1; p < 16; p++) begin
      if (res == 0 && (1 << p) >= n + p + 1) res = p;
    end
    return res;
  endfunction

  // Hamming position of data bit j: positions that are not powers of two.
  function automatic int data_pos(input int j);
    int idx;
    int res;
    idx = -1;
    res = 0;
    for (int q = 3; q < MAX_POS; q++) begin
      if (res == 0 && (q & (q - 1)) != 0) begin
        idx = idx + 1;
        if (idx == j) res = q;
      end
    end
    return res;
  endfunction

  // Data bits covered by check bit i.
  function automatic logic [MAX_DATA_W-1:0] sel_mask(input int i, input int n);
    logic [MAX_DATA_W-1:0] m;
    m = '0;
    for (int j = 0; j < n; j++) begin
      if (((data_pos(j) >> i) & 1) == 1) m[j] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/ecc_parity_net.sv
module ecc_parity_net
  import ecc_enc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 7
) (
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);

  for (genvar i = 0; i < CHK_W; i++) begin : g_chk
    localparam logic [MAX_DATA_W-1:0] SEL = sel_mask(i, DATA_W);
    assign chk[i] = ^(data & SEL[DATA_W-1:0]);
  end

endmodule

// File: rtl/ecc_inject_mask.sv
module ecc_inject_mask
  import ecc_enc_pkg::*;
#(
  parameter int CW_W = 72
) (
  input  logic [1:0]      mode,
  output logic [CW_W-1:0] mask
);

  inj_mode_e mode_e;
  assign mode_e = inj_mode_e'(mode);

  always_comb begin
    mask = '0;
    unique case (mode_e)
      INJ_ONE:  mask[0]   = 1'b1;
      INJ_TWO:  mask[1:0] = 2'b11;
      default:  mask      = '0;
    endcase
  end

endmodule

// File: rtl/ecc_out_pipe.sv
module ecc_out_pipe #(
  parameter int W     = 72,
  parameter bit EXTRA = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] s0_q;

  always_ff @(posedge clk) begin
    if (rst) s0_q <= '0;
    else     s0_q <= d;
  end

  if (EXTRA) begin : g_extra
    logic [W-1:0] s1_q;
    always_ff @(posedge clk) begin
      if (rst) s1_q <= '0;
      else     s1_q <= s0_q;
    end
    assign q = s1_q;
  end else begin : g_direct
    assign q = s0_q;
  end

endmodule

// File: rtl/ecc_secded_encoder.sv
module ecc_secded_encoder
  import ecc_enc_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter bit DED_EN     = 1'b1,
  parameter bit EXTRA_PIPE = 1'b0,
  localparam int CHK_W     = chk_bits(DATA_W),
  localparam int CW_W      = DATA_W + CHK_W + (DED_EN ? 1 : 0)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data_in,
  input  logic [1:0]        inj_mode,
  output logic [CW_W-1:0]   code_out
);

  logic [DATA_W-1:0] data_q;
  logic [1:0]        mode_q;
  logic [CHK_W-1:0]  chk;
  logic [CW_W-1:0]   clean_word;
  logic [CW_W-1:0]   inj_mask;

  // Stage 1: capture the incoming word and its injection control.
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      mode_q <= 2'b00;
    end else begin
      data_q <= data_in;
      mode_q <= inj_mode;
    end
  end

  ecc_parity_net #(
    .DATA_W (DATA_W),
    .CHK_W  (CHK_W)
  ) u_parity (
    .data (data_q),
    .chk  (chk)
  );

  if (DED_EN) begin : g_ded
    assign clean_word = {^{chk, data_q}, chk, data_q};
  end else begin : g_sec
    assign clean_word = {chk, data_q};
  end

  ecc_inject_mask #(
    .CW_W (CW_W)
  ) u_mask (
    .mode (mode_q),
    .mask (inj_mask)
  );

  // Stage 2 (and optional stage 3): registered, possibly corrupted codeword.
  ecc_out_pipe #(
    .W     (CW_W),
    .EXTRA (EXTRA_PIPE)
  ) u_pipe (
    .clk (clk),
    .rst (rst),
    .d   (clean_word ^ inj_mask),
    .q   (code_out)
  );

endmodule

// File: rtl/ecc_secded_encoder_chk.sv
module ecc_secded_encoder_chk #(
  parameter int DATA_W     = 64,
  parameter bit DED_EN     = 1'b1,
  parameter bit EXTRA_PIPE = 1'b0,
  parameter int CW_W       = 72
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] data_in,
  input logic [1:0]        inj_mode,
  input logic [CW_W-1:0]   code_out
);

  localparam int LAT = EXTRA_PIPE ? 3 : 2;

  logic [1:0] run_cnt;
  logic       hist_ok;

  always_ff @(posedge clk) begin
    if (rst)                 run_cnt <= 2'd0;
    else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
  end
  assign hist_ok = (32'(run_cnt) >= LAT);

  AST_DATA_PASS: assert property (@(posedge clk) disable iff (rst)
    hist_ok |-> code_out[DATA_W-1:2] == $past(data_in[DATA_W-1:2], LAT)); // R1

  AST_ONE_FLIP: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && $past(inj_mode, LAT) == 2'b01) |->
      (code_out[0] != $past(data_in[0], LAT) && code_out[1] == $past(data_in[1], LAT))); // R6

  AST_TWO_FLIP: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && $past(inj_mode, LAT) == 2'b10) |->
      (code_out[1:0] == ~$past(data_in[1:0], LAT))); // R7

  AST_NO_FLIP: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && ($past(inj_mode, LAT) == 2'b00 || $past(inj_mode, LAT) == 2'b11)) |->
      (code_out[1:0] == $past(data_in[1:0], LAT))); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> code_out == '0); // R9

  if (DED_EN) begin : g_ded_chk
    AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (rst)
      (hist_ok && $past(inj_mode, LAT) != 2'b01) |-> (^code_out) == 1'b0); // R4
    AST_ODD_ON_ONE: assert property (@(posedge clk) disable iff (rst)
      (hist_ok && $past(inj_mode, LAT) == 2'b01) |-> (^code_out) == 1'b1); // R4
  end

endmodule

bind ecc_secded_encoder ecc_secded_encoder_chk #(
  .DATA_W     (DATA_W),
  .DED_EN     (DED_EN),
  .EXTRA_PIPE (EXTRA_PIPE),
  .CW_W       (CW_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .data_in  (data_in),
  .inj_mode (inj_mode),
  .code_out (code_out)
);

// File: tb/test_ecc_secded_encoder.sv
module test_ecc_secded_encoder;

  localparam int N_VEC = 480;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] data_in = '0;
  logic [1:0]  inj_mode = 2'b00;
  logic [71:0] out_a;
  logic [70:0] out_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [63:0] hist_d [N_VEC];
  logic [1:0]  hist_m [N_VEC];

  always #10 clk = ~clk;

  ecc_secded_encoder i_ecc_secded_encoder (
    .clk (clk), .rst (rst), .data_in (data_in), .inj_mode (inj_mode), .code_out (out_a)
  );

  ecc_secded_encoder #(.DATA_W(64), .DED_EN(1'b0), .EXTRA_PIPE(1'b1)) i_ecc_secded_encoder_p3 (
    .clk (clk), .rst (rst), .data_in (data_in), .inj_mode (inj_mode), .code_out (out_b)
  );

  function automatic logic [71:0] enc72(input logic [63:0] d);
    logic [6:0] c;
    int pos;
    c = '0;
    pos = 3;
    for (int j = 0; j < 64; j++) begin
      while ((pos & (pos - 1)) == 0) pos++;
      for (int i = 0; i < 7; i++) if (((pos >> i) & 1) == 1) c[i] = c[i] ^ d[j];
      pos++;
    end
    return {^{c, d}, c, d};
  endfunction

  function automatic logic [71:0] flip72(input logic [1:0] m);
    if (m == 2'b01) return 72'h1;
    if (m == 2'b10) return 72'h3;
    return 72'h0;
  endfunction

  task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    if (m == 2'b01) return "R6 one-bit flip";
    if (m == 2'b10) return "R7 two-bit flip";
    return "R8 no corruption";
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    // directed corner words first
    for (int k = 0; k < N_VEC; k++) begin
      hist_d[k] = {$urandom, $urandom};
      hist_m[k] = 2'($urandom % 4);
    end
    hist_d[0] = '0;            hist_m[0] = 2'b00;
    hist_d[1] = '1;            hist_m[1] = 2'b00;
    hist_d[2] = '0;            hist_m[2] = 2'b01;
    hist_d[3] = '0;            hist_m[3] = 2'b10;
    hist_d[4] = '1;            hist_m[4] = 2'b11;
    for (int b = 0; b < 64; b++) begin
      hist_d[5 + b] = 64'h1 << b;
      hist_m[5 + b] = 2'b00;
    end

    // R2: codeword widths
    n_checks++;
    if ($bits(out_a) != 72 || $bits(out_b) != 71) begin
      n_fail++;
      $display("FAIL R2 width actual=%0d/%0d expected=72/71", $bits(out_a), $bits(out_b));
    end

    // R9: outputs clear under reset
    repeat (4) @(negedge clk);
    check("R9 reset clears output (2-stage)", out_a, 72'h0);
    check("R9 reset clears output (3-stage)", {1'b0, out_b}, 72'h0);
    rst = 1'b0;

    // R1, R3, R4, R5-R8: streaming, one word per cycle
    for (int k = 0; k < N_VEC + 3; k++) begin
      if (k >= 2) begin
        logic [71:0] e;
        e = enc72(hist_d[k-2]) ^ flip72(hist_m[k-2]);
        check({"R1 data field / ", mode_tag(hist_m[k-2])}, {8'h0, out_a[63:0]}, {8'h0, e[63:0]});
        check("R3 check bits", {65'h0, out_a[70:64]}, {65'h0, e[70:64]});
        check("R4 overall parity", {71'h0, out_a[71]}, {71'h0, e[71]});
      end
      if (k >= 3) begin
        logic [71:0] e3;
        e3 = enc72(hist_d[k-3]) ^ flip72(hist_m[k-3]);
        check("R5 three-cycle latency, no DED bit", {1'b0, out_b}, {1'b0, e3[70:0]});
      end
      if (k < N_VEC) begin
        data_in  = hist_d[k];
        inj_mode = hist_m[k];
      end else begin
        data_in  = '0;
        inj_mode = 2'b00;
      end
      @(negedge clk);
    end

    // R9: mid-run synchronous reset
    data_in  = 64'hDEAD_BEEF_0123_4567;
    inj_mode = 2'b10;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 sync reset mid-stream (2-stage)", out_a, 72'h0);
    check("R9 sync reset mid-stream (3-stage)", {1'b0, out_b}, 72'h0);
    rst = 1'b0;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule